// File: doc/BRIEF.md
# Host-Polled Ethernet Frame Buffer Port

This block sits between a processor bus and an Ethernet MAC and lets software move whole frames without any DMA engine. Each direction holds exactly one frame in a word buffer. Software fills the transmit buffer one 32-bit word at a time and then hands the frame over by setting a ready flag together with the byte length. The block streams the bytes to the MAC and drops the flag when the last byte has been taken.

On the receive side the MAC streams bytes in. They are packed into words, most significant byte first. When the final byte arrives, the block raises a receive ready flag with the byte count and two error indications. Software reads the words out, then writes the receive control register with the ready bit clear to give the buffer back. A two-source interrupt (receive-ready, transmit-done) with a per-source enable lets software avoid polling.

Registers sit at fixed word offsets: transmit control 0x800, transmit data 0x808, receive control 0x810, receive data 0x818, interrupt enable 0x8C0, interrupt cause 0x8C4. Read data is returned on `bus_rdata` one cycle after the read strobe and is held until the next read.

Top module: `frame_port`

## Requirements
- R1: After reset, all four control and interrupt registers read zero, `irq` is low, `mac_rx_ready` is high and `mac_tx_valid` is low.
- R2: Words written to 0x808 while the transmit flag is clear are queued in order. Writing 0x800 with bit 15 set and a length L in bits 10:0 makes the block emit exactly L bytes. Each word is sent from bits 31:24 down to bits 7:0, and `mac_tx_last` is asserted on byte L.
- R3: Bit 15 of 0x800 reads 1 from the start of a frame until its last byte is accepted, and 0 afterwards. Bit 14 then holds `mac_tx_err` as sampled with the last byte. A frame of length 0 completes with no byte output.
- R4: While the transmit flag is set, writes to 0x808 are discarded and writes to 0x800 leave the register unchanged.
- R5: While `mac_tx_valid` is high and `mac_tx_ready` is low, the byte on `mac_tx_data` is held and `mac_tx_valid` stays high.
- R6: When the last received byte is accepted, 0x810 reads as follows: bit 15 = 1, bits 10:0 = the byte count, bit 14 = the `mac_rx_err` value of the last byte or a truncation, bit 13 = the `mac_rx_crc_err` value of the last byte.
- R7: Reads of 0x818 return the received words in order, with the first byte in bits 31:24 and the unused low bytes of the final word reading zero. A read with no frame held, or after the last word, returns zero.
- R8: While the receive flag is set, `mac_rx_ready` is low and no byte is accepted.
- R9: A write to 0x810 with bit 15 clear releases a held frame: the flag clears and any undrained words are discarded, so the next frame reads back intact.
- R10: Received bytes beyond 2^LEN_W-4 (2044 by default) are dropped. The length saturates there and bit 14 of 0x810 is set.
- R11: Cause register 0x8C4 bit 0 sets when the receive flag rises and clears on release. Bit 1 sets when the transmit flag falls and clears on any write to 0x800.
- R12: Enable register 0x8C0 bits 1:0 are read/write. `irq` is high exactly when a cause bit and its matching enable bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 13 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Interrupt request |
| mac_tx_valid | output | 1 | Transmit byte valid |
| mac_tx_ready | input | 1 | MAC accepts the transmit byte |
| mac_tx_data | output | 8 | Transmit byte |
| mac_tx_last | output | 1 | Final byte of the frame |
| mac_tx_err | input | 1 | MAC transmit error, sampled with the final byte |
| mac_rx_valid | input | 1 | Receive byte valid |
| mac_rx_ready | output | 1 | Block can accept a receive byte |
| mac_rx_data | input | 8 | Receive byte |
| mac_rx_last | input | 1 | Final received byte |
| mac_rx_err | input | 1 | Receive error, valid with the final byte |
| mac_rx_crc_err | input | 1 | CRC error, valid with the final byte |

## Verification
Frames are tried at lengths 60 to 63 so that every final-word fill of one to four bytes is covered, checking that the byte order and the zeroed tail lanes are right in each case. A one-byte frame and a 130-byte frame cover the shortest case and a multi-word run with a partial tail. Each length is combined with different error-flag settings, and on transmit with a MAC that throttles acceptance, so that flag latching is separated from data movement. Directed cases exercise the following: a zero-length transmit, writes made while a frame is in flight, a frame arriving while the receive buffer is occupied, a release that leaves words unread, a receive overrun past the buffer limit, and interrupt masking.

// File: rtl/frame_port_pkg.sv
package frame_port_pkg;

  localparam int unsigned REG_AW = 13;

  localparam logic [REG_AW-1:0] OFS_TX_CTL    = 13'h800;
  localparam logic [REG_AW-1:0] OFS_TX_DAT    = 13'h808;
  localparam logic [REG_AW-1:0] OFS_RX_CTL    = 13'h810;
  localparam logic [REG_AW-1:0] OFS_RX_DAT    = 13'h818;
  localparam logic [REG_AW-1:0] OFS_IRQ_EN    = 13'h8C0;
  localparam logic [REG_AW-1:0] OFS_IRQ_CAUSE = 13'h8C4;

  // control register field positions
  localparam int unsigned BIT_RDY = 15;
  localparam int unsigned BIT_ERR = 14;
  localparam int unsigned BIT_CRC = 13;

  // interrupt source positions
  localparam int unsigned IRQ_RX = 0;
  localparam int unsigned IRQ_TX = 1;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_TX_CTL, SEL_TX_DAT, SEL_RX_CTL, SEL_RX_DAT, SEL_IRQ_EN, SEL_IRQ_CAUSE
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [REG_AW-1:0] a);
    case (a)
      OFS_TX_CTL:    return SEL_TX_CTL;
      OFS_TX_DAT:    return SEL_TX_DAT;
      OFS_RX_CTL:    return SEL_RX_CTL;
      OFS_RX_DAT:    return SEL_RX_DAT;
      OFS_IRQ_EN:    return SEL_IRQ_EN;
      OFS_IRQ_CAUSE: return SEL_IRQ_CAUSE;
      default:       return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/frame_port_fifo.sv
module frame_port_fifo #(
  parameter int unsigned AW = 9,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          empty
);
  localparam int unsigned DEPTH = 2 ** AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wr_q, wr_n, rd_q, rd_n;
  logic          full, push_ok, pop_ok;

  assign empty   = (wr_q == rd_q);
  assign full    = (wr_q[AW] != rd_q[AW]) && (wr_q[AW-1:0] == rd_q[AW-1:0]);
  assign push_ok = push && !full && !clr;
  assign pop_ok  = pop && !empty && !clr;
  assign rdata   = mem[rd_q[AW-1:0]];

  always_comb begin
    wr_n = wr_q;
    rd_n = rd_q;
    if (clr) begin
      wr_n = '0;
      rd_n = '0;
    end else begin
      if (push_ok) wr_n = wr_q + (AW+1)'(1);
      if (pop_ok)  rd_n = rd_q + (AW+1)'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      wr_q <= wr_n;
      rd_q <= rd_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q[AW-1:0]] <= wdata;
  end

endmodule

// File: rtl/frame_port_tx.sv
module frame_port_tx #(
  parameter int unsigned LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] start_len,
  input  logic [31:0]      head,
  input  logic             head_valid,
  output logic             pop,
  output logic             mac_tx_valid,
  input  logic             mac_tx_ready,
  output logic [7:0]       mac_tx_data,
  output logic             mac_tx_last,
  input  logic             mac_tx_err,
  output logic             done,
  output logic             done_err
);
  logic             busy_q, busy_n, zero_q, zero_n;
  logic [LEN_W-1:0] cnt_q, cnt_n, len_q, len_n;
  logic             fire;
  logic [1:0]       lane;

  assign lane         = cnt_q[1:0];
  assign mac_tx_valid = busy_q && head_valid;
  assign mac_tx_last  = (cnt_q == len_q - LEN_W'(1));
  assign fire         = mac_tx_valid && mac_tx_ready;
  assign pop          = fire && ((lane == 2'd3) || mac_tx_last);
  assign done         = (fire && mac_tx_last) || zero_q;
  assign done_err     = fire && mac_tx_last && mac_tx_err;

  always_comb begin
    case (lane)
      2'd0:    mac_tx_data = head[31:24];
      2'd1:    mac_tx_data = head[23:16];
      2'd2:    mac_tx_data = head[15:8];
      default: mac_tx_data = head[7:0];
    endcase
  end

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    len_n  = len_q;
    zero_n = start && (start_len == '0);
    if (start && (start_len != '0)) begin
      busy_n = 1'b1;
      cnt_n  = '0;
      len_n  = start_len;
    end else if (fire) begin
      if (mac_tx_last) busy_n = 1'b0;
      else             cnt_n  = cnt_q + LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      zero_q <= 1'b0;
      cnt_q  <= '0;
      len_q  <= '0;
    end else begin
      busy_q <= busy_n;
      zero_q <= zero_n;
      cnt_q  <= cnt_n;
      len_q  <= len_n;
    end
  end

endmodule

// File: rtl/frame_port_rx.sv
module frame_port_rx #(
  parameter int unsigned LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open,
  input  logic             mac_rx_valid,
  output logic             mac_rx_ready,
  input  logic [7:0]       mac_rx_data,
  input  logic             mac_rx_last,
  input  logic             mac_rx_err,
  input  logic             mac_rx_crc_err,
  output logic             push,
  output logic [31:0]      push_word,
  output logic             done,
  output logic [LEN_W-1:0] done_len,
  output logic             done_err,
  output logic             done_crc
);
  localparam logic [LEN_W-1:0] MAX_BYTES = LEN_W'(2 ** LEN_W - 4);

  logic [LEN_W-1:0] cnt_q, cnt_n;
  logic [31:0]      asm_q, asm_n;
  logic             ovf_q, ovf_n;
  logic             accept, store;

  assign mac_rx_ready = open;
  assign accept       = mac_rx_valid && open;
  assign store        = (cnt_q < MAX_BYTES);
  assign push         = accept && store && ((cnt_q[1:0] == 2'd3) || mac_rx_last);
  assign done         = accept && mac_rx_last;
  assign done_len     = store ? cnt_q + LEN_W'(1) : cnt_q;
  assign done_err     = mac_rx_err || ovf_q || !store;
  assign done_crc     = mac_rx_crc_err;

  always_comb begin
    case (cnt_q[1:0])
      2'd0:    push_word = {mac_rx_data, 24'h0};
      2'd1:    push_word = {asm_q[31:24], mac_rx_data, 16'h0};
      2'd2:    push_word = {asm_q[31:16], mac_rx_data, 8'h0};
      default: push_word = {asm_q[31:8], mac_rx_data};
    endcase
  end

  always_comb begin
    cnt_n = cnt_q;
    asm_n = asm_q;
    ovf_n = ovf_q;
    if (accept) begin
      if (store) asm_n = push_word;
      if (mac_rx_last) begin
        cnt_n = '0;
        ovf_n = 1'b0;
      end else if (store) begin
        cnt_n = cnt_q + LEN_W'(1);
      end else begin
        ovf_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      asm_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      asm_q <= asm_n;
      ovf_q <= ovf_n;
    end
  end

endmodule

// File: rtl/frame_port.sv
module frame_port #(
  parameter int unsigned LEN_W = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [12:0] bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        mac_tx_valid,
  input  logic        mac_tx_ready,
  output logic [7:0]  mac_tx_data,
  output logic        mac_tx_last,
  input  logic        mac_tx_err,
  input  logic        mac_rx_valid,
  output logic        mac_rx_ready,
  input  logic [7:0]  mac_rx_data,
  input  logic        mac_rx_last,
  input  logic        mac_rx_err,
  input  logic        mac_rx_crc_err
);
  import frame_port_pkg::*;

  localparam int unsigned FIFO_AW = LEN_W - 2;

  // reset: asserted asynchronously, released on the clock
  logic rs_q1, rs_q2, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rs_q2, rs_q1} <= 2'b00;
    else        {rs_q2, rs_q1} <= {rs_q1, 1'b1};
  end
  assign rst_s = rs_q2;

  reg_sel_e sel;
  assign sel = decode_addr(bus_addr);

  logic             tx_rdy_q, tx_rdy_n, tx_err_q, tx_err_n;
  logic [LEN_W-1:0] tx_len_q, tx_len_n;
  logic             rx_rdy_q, rx_rdy_n, rx_err_q, rx_err_n, rx_crc_q, rx_crc_n;
  logic [LEN_W-1:0] rx_len_q, rx_len_n;
  logic [1:0]       ien_q, ien_n, cause_q, cause_n;
  logic [31:0]      rdata_q, rdata_n, rd_word;

  logic             tx_push, tx_start, tx_pop, tx_done, tx_done_err, tx_empty;
  logic [31:0]      tx_head;
  logic             rx_push, rx_pop, rx_release, rx_done, rx_done_err, rx_done_crc, rx_empty;
  logic [31:0]      rx_word, rx_head;
  logic [LEN_W-1:0] rx_done_len;

  assign tx_push    = bus_wr && (sel == SEL_TX_DAT) && !tx_rdy_q;
  assign tx_start   = bus_wr && (sel == SEL_TX_CTL) && !tx_rdy_q && bus_wdata[BIT_RDY];
  assign rx_release = bus_wr && (sel == SEL_RX_CTL) && !bus_wdata[BIT_RDY] && rx_rdy_q;
  assign rx_pop     = bus_rd && (sel == SEL_RX_DAT) && rx_rdy_q && !rx_empty;

  frame_port_fifo #(.AW(FIFO_AW), .DW(32)) u_tx_fifo (
    .clk(clk), .rst_n(rst_s), .clr(1'b0), .push(tx_push), .wdata(bus_wdata),
    .pop(tx_pop), .rdata(tx_head), .empty(tx_empty)
  );

  frame_port_tx #(.LEN_W(LEN_W)) u_tx (
    .clk(clk), .rst_n(rst_s), .start(tx_start), .start_len(bus_wdata[LEN_W-1:0]),
    .head(tx_head), .head_valid(!tx_empty), .pop(tx_pop),
    .mac_tx_valid(mac_tx_valid), .mac_tx_ready(mac_tx_ready), .mac_tx_data(mac_tx_data),
    .mac_tx_last(mac_tx_last), .mac_tx_err(mac_tx_err),
    .done(tx_done), .done_err(tx_done_err)
  );

  frame_port_fifo #(.AW(FIFO_AW), .DW(32)) u_rx_fifo (
    .clk(clk), .rst_n(rst_s), .clr(rx_release), .push(rx_push), .wdata(rx_word),
    .pop(rx_pop), .rdata(rx_head), .empty(rx_empty)
  );

  frame_port_rx #(.LEN_W(LEN_W)) u_rx (
    .clk(clk), .rst_n(rst_s), .open(!rx_rdy_q),
    .mac_rx_valid(mac_rx_valid), .mac_rx_ready(mac_rx_ready), .mac_rx_data(mac_rx_data),
    .mac_rx_last(mac_rx_last), .mac_rx_err(mac_rx_err), .mac_rx_crc_err(mac_rx_crc_err),
    .push(rx_push), .push_word(rx_word), .done(rx_done), .done_len(rx_done_len),
    .done_err(rx_done_err), .done_crc(rx_done_crc)
  );

  always_comb begin
    rd_word = '0;
    case (sel)
      SEL_TX_CTL: begin
        rd_word[BIT_RDY]     = tx_rdy_q;
        rd_word[BIT_ERR]     = tx_err_q;
        rd_word[LEN_W-1:0]   = tx_len_q;
      end
      SEL_RX_CTL: begin
        rd_word[BIT_RDY]     = rx_rdy_q;
        rd_word[BIT_ERR]     = rx_err_q;
        rd_word[BIT_CRC]     = rx_crc_q;
        rd_word[LEN_W-1:0]   = rx_len_q;
      end
      SEL_RX_DAT:    rd_word = rx_pop ? rx_head : '0;
      SEL_IRQ_EN:    rd_word[1:0] = ien_q;
      SEL_IRQ_CAUSE: rd_word[1:0] = cause_q;
      default:       rd_word = '0;
    endcase
  end

  always_comb begin
    tx_rdy_n = tx_rdy_q;
    tx_err_n = tx_err_q;
    tx_len_n = tx_len_q;
    rx_rdy_n = rx_rdy_q;
    rx_err_n = rx_err_q;
    rx_crc_n = rx_crc_q;
    rx_len_n = rx_len_q;
    ien_n    = ien_q;
    cause_n  = cause_q;
    rdata_n  = bus_rd ? rd_word : rdata_q;
    if (tx_start) begin
      tx_rdy_n = 1'b1;
      tx_err_n = 1'b0;
      tx_len_n = bus_wdata[LEN_W-1:0];
    end
    if (bus_wr && (sel == SEL_TX_CTL)) cause_n[IRQ_TX] = 1'b0;
    if (tx_done) begin
      tx_rdy_n        = 1'b0;
      tx_err_n        = tx_done_err;
      cause_n[IRQ_TX] = 1'b1;
    end
    if (rx_release) begin
      rx_rdy_n        = 1'b0;
      cause_n[IRQ_RX] = 1'b0;
    end
    if (rx_done) begin
      rx_rdy_n        = 1'b1;
      rx_len_n        = rx_done_len;
      rx_err_n        = rx_done_err;
      rx_crc_n        = rx_done_crc;
      cause_n[IRQ_RX] = 1'b1;
    end
    if (bus_wr && (sel == SEL_IRQ_EN)) ien_n = bus_wdata[1:0];
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      tx_rdy_q <= 1'b0;
      tx_err_q <= 1'b0;
      tx_len_q <= '0;
      rx_rdy_q <= 1'b0;
      rx_err_q <= 1'b0;
      rx_crc_q <= 1'b0;
      rx_len_q <= '0;
      ien_q    <= '0;
      cause_q  <= '0;
      rdata_q  <= '0;
    end else begin
      tx_rdy_q <= tx_rdy_n;
      tx_err_q <= tx_err_n;
      tx_len_q <= tx_len_n;
      rx_rdy_q <= rx_rdy_n;
      rx_err_q <= rx_err_n;
      rx_crc_q <= rx_crc_n;
      rx_len_q <= rx_len_n;
      ien_q    <= ien_n;
      cause_q  <= cause_n;
      rdata_q  <= rdata_n;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = |(cause_q & ien_q);

endmodule

// File: rtl/frame_port_chk.sv
module frame_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_rdy,
  input logic       rx_rdy,
  input logic [1:0] cause,
  input logic [1:0] ien,
  input logic       irq,
  input logic       mac_tx_valid,
  input logic       mac_tx_ready,
  input logic [7:0] mac_tx_data,
  input logic       mac_rx_ready
);
  // R5
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_tx_valid && !mac_tx_ready) |=> (mac_tx_valid && $stable(mac_tx_data)));

  // R3
  tx_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mac_tx_valid |-> tx_rdy);

  // R8
  rx_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rdy |-> !mac_rx_ready);

  // R11
  tx_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_rdy) |-> cause[1]);

  // R11
  rx_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_rdy) |-> cause[0]);

  // R12
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == 2'b00) |-> !irq);

endmodule

bind frame_port frame_port_chk u_chk (
  .clk(clk), .rst_n(rst_s), .tx_rdy(tx_rdy_q), .rx_rdy(rx_rdy_q), .cause(cause_q),
  .ien(ien_q), .irq(irq), .mac_tx_valid(mac_tx_valid), .mac_tx_ready(mac_tx_ready),
  .mac_tx_data(mac_tx_data), .mac_rx_ready(mac_rx_ready)
);

// File: tb/frame_port_bench.sv
module frame_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [12:0] A_TXC = 13'h800, A_TXD = 13'h808, A_RXC = 13'h810,
                          A_RXD = 13'h818, A_IEN = 13'h8C0, A_CAU = 13'h8C4;
  localparam int NV = 6;
  localparam int VLEN [NV] = '{60, 61, 62, 63, 1, 130};
  // bit0: error flag, bit1: crc flag (rx) / throttled MAC (tx)
  localparam int VFLG [NV] = '{0, 1, 2, 3, 2, 1};

  logic        clk = 1'b0;
  logic        rst_n;
  logic [12:0] bus_addr;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq;
  logic        mac_tx_valid, mac_tx_ready, mac_tx_last, mac_tx_err;
  logic [7:0]  mac_tx_data;
  logic        mac_rx_valid, mac_rx_ready, mac_rx_last, mac_rx_err, mac_rx_crc_err;
  logic [7:0]  mac_rx_data;

  int n_tests = 0, n_fail = 0;
  int rdy_mode = 0, tick = 0;
  logic [7:0] cap [4096];
  int cap_n = 0, cap_last = -1;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_port u_frame_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .mac_tx_valid(mac_tx_valid), .mac_tx_ready(mac_tx_ready), .mac_tx_data(mac_tx_data),
    .mac_tx_last(mac_tx_last), .mac_tx_err(mac_tx_err),
    .mac_rx_valid(mac_rx_valid), .mac_rx_ready(mac_rx_ready), .mac_rx_data(mac_rx_data),
    .mac_rx_last(mac_rx_last), .mac_rx_err(mac_rx_err), .mac_rx_crc_err(mac_rx_crc_err)
  );

  function automatic logic [7:0] pat(int seed, int i);
    return 8'((seed * 37 + i * 11 + (i >> 8)) & 255);
  endfunction

  function automatic logic [31:0] expw(int seed, int len, int k);
    logic [31:0] w = '0;
    for (int b = 0; b < 4; b++)
      if (4 * k + b < len) w[31 - 8 * b -: 8] = pat(seed, 4 * k + b);
    return w;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [12:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [12:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  // MAC transmit acceptance pattern, changed just after each rising edge
  initial begin
    mac_tx_ready = 1'b1;
    forever begin
      @(posedge clk);
      #1;
      case (rdy_mode)
        0:       mac_tx_ready = 1'b1;
        1:       mac_tx_ready = (tick % 3 != 2);
        default: mac_tx_ready = 1'b0;
      endcase
      tick++;
    end
  end

  // record bytes the MAC accepts at the coming rising edge
  always @(negedge clk) begin
    if (mac_tx_valid && mac_tx_ready) begin
      cap[cap_n] = mac_tx_data;
      if (mac_tx_last) cap_last = cap_n;
      cap_n++;
    end
  end

  task automatic send_rx(int len, int seed, bit e, bit c);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      mac_rx_valid = 1'b1;
      mac_rx_data  = pat(seed, i);
      mac_rx_last  = (i == len - 1);
      mac_rx_err   = e && (i == len - 1);
      mac_rx_crc_err = c && (i == len - 1);
    end
    @(negedge clk);
    mac_rx_valid = 1'b0; mac_rx_last = 1'b0; mac_rx_err = 1'b0; mac_rx_crc_err = 1'b0;
  endtask

  task automatic load_tx(int len, int seed);
    for (int k = 0; k < (len + 3) / 4; k++) bus_write(A_TXD, expw(seed, len, k));
  endtask

  task automatic wait_tx_idle(output bit ok);
    logic [31:0] d;
    ok = 0;
    for (int k = 0; k < 3000; k++) begin
      bus_read(A_TXC, d);
      if (!d[15]) begin ok = 1; break; end
    end
  endtask

  task automatic check_tx_bytes(string req, int len, int seed);
    int bad = 0;
    for (int i = 0; i < len; i++) if (cap[i] !== pat(seed, i)) bad++;
    chk({req, " byte count"}, 32'(cap_n), 32'(len));
    chk({req, " byte values"}, 32'(bad), 0);
    if (len > 0) chk({req, " last marker"}, 32'(cap_last), 32'(len - 1));
  endtask

  task automatic read_rx_words(string req, int len, int seed);
    logic [31:0] d;
    int bad = 0;
    for (int k = 0; k < (len + 3) / 4; k++) begin
      bus_read(A_RXD, d);
      if (d !== expw(seed, len, k)) bad++;
    end
    chk({req, " words"}, 32'(bad), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    bit ok;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
    mac_tx_err = 0; mac_rx_valid = 0; mac_rx_data = '0; mac_rx_last = 0;
    mac_rx_err = 0; mac_rx_crc_err = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 rx ready", 32'(mac_rx_ready), 1);
    chk("R1 tx valid", 32'(mac_tx_valid), 0);
    bus_read(A_TXC, d); chk("R1 tx ctl", d, 0);
    bus_read(A_RXC, d); chk("R1 rx ctl", d, 0);
    bus_read(A_IEN, d); chk("R1 enable", d, 0);
    bus_read(A_CAU, d); chk("R1 cause", d, 0);
    // R7 empty read
    bus_read(A_RXD, d); chk("R7 empty read", d, 0);

    // R12 enable readback
    bus_write(A_IEN, 32'h3);
    bus_read(A_IEN, d); chk("R12 enable readback", d, 32'h3);

    // vector table walk
    for (int v = 0; v < NV; v++) begin
      int len = VLEN[v];
      int fl  = VFLG[v];
      // receive
      send_rx(len, v + 1, fl[0], fl[1]);
      chk("R8 rx ready low", 32'(mac_rx_ready), 0);
      chk("R12 irq on rx", 32'(irq), 1);
      bus_read(A_RXC, d);
      chk("R6 rx ctl", d, 32'h8000 | (32'(fl[0]) << 14) | (32'(fl[1]) << 13) | 32'(len));
      bus_read(A_CAU, d); chk("R11 rx cause set", 32'(d[0]), 1);
      read_rx_words("R7", len, v + 1);
      bus_read(A_RXD, d); chk("R7 read past end", d, 0);
      bus_write(A_RXC, 32'h0);
      bus_read(A_CAU, d); chk("R11 rx cause cleared", 32'(d[0]), 0);
      bus_read(A_RXC, d); chk("R9 rx flag cleared", 32'(d[15]), 0);
      // transmit
      cap_n = 0; cap_last = -1;
      rdy_mode = fl[1] ? 1 : 0;
      mac_tx_err = fl[0];
      load_tx(len, v + 11);
      bus_write(A_TXC, 32'h8000 | 32'(len));
      wait_tx_idle(ok);
      chk("R3 tx completes", 32'(ok), 1);
      check_tx_bytes("R2", len, v + 11);
      bus_read(A_TXC, d); chk("R3 tx ctl after", d, (32'(fl[0]) << 14) | 32'(len));
      chk("R12 irq on tx", 32'(irq), 1);
      bus_read(A_CAU, d); chk("R11 tx cause set", 32'(d[1]), 1);
      bus_write(A_TXC, 32'h0);
      bus_read(A_CAU, d); chk("R11 tx cause cleared", 32'(d[1]), 0);
      mac_tx_err = 0; rdy_mode = 0;
    end

    // R3 zero length frame
    cap_n = 0;
    bus_write(A_TXC, 32'h8000);
    repeat (3) @(negedge clk);
    bus_read(A_TXC, d); chk("R3 zero length done", d, 0);
    chk("R3 zero length no bytes", 32'(cap_n), 0);
    bus_read(A_CAU, d); chk("R11 zero length cause", 32'(d[1]), 1);
    bus_write(A_TXC, 32'h0);

    // R4 writes during an active frame
    rdy_mode = 2;
    cap_n = 0; cap_last = -1;
    load_tx(8, 20);
    bus_write(A_TXC, 32'h8008);
    bus_write(A_TXD, 32'hDEADBEEF);
    bus_write(A_TXC, 32'h8003);
    bus_read(A_TXC, d); chk("R4 ctl unchanged", d, 32'h8008);
    rdy_mode = 0;
    wait_tx_idle(ok);
    check_tx_bytes("R4 first", 8, 20);
    cap_n = 0; cap_last = -1;
    load_tx(4, 21);
    bus_write(A_TXC, 32'h8004);
    wait_tx_idle(ok);
    check_tx_bytes("R4 next frame", 4, 21);
    bus_write(A_TXC, 32'h0);

    // R8 frame arriving while buffer held
    send_rx(9, 30, 0, 0);
    send_rx(5, 31, 1, 1);
    chk("R8 still blocked", 32'(mac_rx_ready), 0);
    bus_read(A_RXC, d); chk("R8 ctl unchanged", d, 32'h8009);
    read_rx_words("R8 held frame", 9, 30);
    bus_write(A_RXC, 32'h0);
    chk("R8 ready after release", 32'(mac_rx_ready), 1);

    // R9 release with words unread
    send_rx(16, 40, 0, 0);
    bus_read(A_RXD, d); chk("R9 first word", d, expw(40, 16, 0));
    bus_write(A_RXC, 32'h0);
    send_rx(8, 41, 0, 0);
    read_rx_words("R9 next frame", 8, 41);
    bus_read(A_RXD, d); chk("R9 no stale words", d, 0);
    bus_write(A_RXC, 32'h0);

    // R10 overrun
    send_rx(2050, 50, 0, 0);
    bus_read(A_RXC, d); chk("R10 truncated ctl", d, 32'h8000 | 32'h4000 | 32'd2044);
    read_rx_words("R10", 2044, 50);
    bus_read(A_RXD, d); chk("R10 past limit", d, 0);
    bus_write(A_RXC, 32'h0);

    // R12 masking
    bus_write(A_IEN, 32'h0);
    send_rx(4, 60, 0, 0);
    chk("R12 irq masked", 32'(irq), 0);
    bus_read(A_CAU, d); chk("R12 cause while masked", d, 32'h1);
    bus_write(A_IEN, 32'h2);
    chk("R12 other source enabled", 32'(irq), 0);
    bus_write(A_IEN, 32'h1);
    chk("R12 irq unmasked", 32'(irq), 1);
    bus_write(A_RXC, 32'h0);
    chk("R12 irq after release", 32'(irq), 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule